// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the command side of a serial flash target on an SPI bus. It watches an active-low chip select, a serial clock and a serial data input. It drives a serial data output together with a separate output-enable, so the chip's pad ring can build the tri-state driver. The pins are brought into the block's own clock domain through short synchronizer chains, and every action is taken on a detected edge of the synchronized serial clock or chip select. Both SPI mode 0 (clock idles low) and mode 3 (clock idles high) are accepted, because only edges are used.

Four 8-bit commands are decoded: two enable commands, a status write and an identification read. The write-enable command (06h) and the status-write-enable command (50h) each set their own latch. The status write command (01h) stores one or two data bytes into a 16-bit status/configuration register, provided that one of the latches is set. The identification read (9Fh) streams a fixed three-byte identifier, and repeats it for as long as clocks keep arriving. The status register and both latches are outputs so that the surrounding logic can observe them.

Top module: `spiflash_front`

## Requirements
- R1: Modes 0 and 3 both work: SDI is sampled on rising SCK, SDO changes on falling SCK, and every byte travels MSB first.
- R2: `sdo_en` is 0 while the opcode bits arrive, between frames, and for the whole of any frame whose opcode is not 9Fh.
- R3: After opcode 9Fh, SDO carries BFh, then 25h, then 8Ch. The 24-bit sequence then starts again from BFh on further clocks.
- R4: A rising chip select during the identification output drops `sdo_en` to 0 three `clk` edges after the pin change.
- R5: A frame of exactly 8 bits carrying 06h sets `wel_q`. A frame of exactly 8 bits carrying 50h sets `ewsl_q`. Either latch changes only when chip select rises.
- R6: A 01h frame of exactly 16 bits, sent while a latch is set, writes its data byte to `status_q[7:0]` and leaves `status_q[15:8]` unchanged.
- R7: A 01h frame of exactly 24 bits, sent while a latch is set, writes the first data byte to `status_q[7:0]` and the second data byte to `status_q[15:8]`.
- R8: A 01h frame of any other length (partial byte, partial word, or extra clocks) leaves `status_q` unchanged.
- R9: A 01h frame sent while both latches are clear leaves `status_q` unchanged.
- R10: When chip select rises on any frame whose complete opcode is 01h, both `wel_q` and `ewsl_q` are cleared.
- R11: After reset, `status_q` is 0000h, both latches are 0, and `sdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, several times faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| sdi | input | 1 | SPI serial data into the block |
| sdo | output | 1 | SPI serial data out of the block |
| sdo_en | output | 1 | Output enable for `sdo`; 0 means high impedance |
| status_q | output | 16 | Status/configuration register |
| wel_q | output | 1 | Write-enable latch |
| ewsl_q | output | 1 | Status-write-enable latch |

## Verification
Each pin change passes through two synchronizer flops before an edge can be detected, and the register that acts on that edge is loaded on the third `clk` edge after the change. So an SDO bit is due three cycles after SCK falls, and a status or latch update is due three cycles after chip select rises. The bench holds each SCK level for eight `clk` cycles and reads SDO just before the next rising SCK, well past the three-cycle latency. It waits ten cycles after raising chip select before comparing the status register, the latches and `sdo_en` against its own model.

// File: rtl/spiflash_pkg.sv
package spiflash_pkg;

  localparam int OPW    = 8;
  localparam int STAT_W = 16;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_EWSR = 8'h50;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDID = 8'h9F;

  typedef enum logic [1:0] {
    LEN_BAD  = 2'd0,
    LEN_BYTE = 2'd1,
    LEN_WORD = 2'd2
  } wrsr_len_e;

  // Frame length (opcode plus data bits) to status-write form
  function automatic wrsr_len_e classify_len(input int unsigned nbits);
    if (nbits == OPW + 8)       return LEN_BYTE;
    else if (nbits == OPW + 16) return LEN_WORD;
    else                        return LEN_BAD;
  endfunction

  // New status value: the first byte received always lands in the low byte
  function automatic logic [STAT_W-1:0] wrsr_merge(input logic [STAT_W-1:0] old_v,
                                                   input logic [STAT_W-1:0] shifted,
                                                   input wrsr_len_e len);
    if (len == LEN_WORD) return {shifted[7:0], shifted[15:8]};
    else                 return {old_v[15:8], shifted[7:0]};
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic sdi_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_fall
);
  // one extra flop past the synchronizer holds the previous level
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] cs_p, sck_p, sdi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p  <= '1;
      sck_p <= '0;
      sdi_p <= '0;
    end else begin
      cs_p  <= {cs_p[DEPTH-2:0], cs_n};
      sck_p <= {sck_p[DEPTH-2:0], sck};
      sdi_p <= {sdi_p[DEPTH-2:0], sdi};
    end
  end

  logic cs_now, cs_was, sck_now, sck_was, frame_on;
  assign cs_now   = cs_p[STAGES-1];
  assign cs_was   = cs_p[STAGES];
  assign sck_now  = sck_p[STAGES-1];
  assign sck_was  = sck_p[STAGES];
  assign frame_on = ~cs_now;

  assign sdi_s    = sdi_p[STAGES-1];
  assign cs_rise  = cs_now & ~cs_was;
  assign cs_fall  = ~cs_now & cs_was;
  assign sck_rise = frame_on & sck_now & ~sck_was;
  assign sck_fall = frame_on & ~sck_now & sck_was;

  logic unused_sdi;
  assign unused_sdi = sdi_p[STAGES];
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spiflash_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              sdi_s,
  output logic [CNT_W-1:0]  bitcnt,
  output logic [7:0]        opcode,
  output logic              op_valid,
  output logic [STAT_W-1:0] data_sr,
  output logic              id_active
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OPW - 1);
  localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(OPW);
  localparam logic [CNT_W-1:0] CNT_DEND = CNT_W'(OPW + STAT_W);

  logic [OPW-1:0] op_sr;
  logic           in_opcode, in_data;

  assign in_opcode = bitcnt < CNT_OP;
  assign in_data   = (bitcnt >= CNT_OP) && (bitcnt < CNT_DEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt   <= '0;
      op_sr    <= '0;
      opcode   <= '0;
      op_valid <= 1'b0;
      data_sr  <= '0;
    end else if (cs_rise || cs_fall) begin
      bitcnt   <= '0;
      op_valid <= 1'b0;
    end else if (sck_rise) begin
      if (bitcnt != CNT_MAX) bitcnt <= bitcnt + 1'b1;
      if (in_opcode) begin
        op_sr <= {op_sr[OPW-2:0], sdi_s};
        if (bitcnt == CNT_LAST) begin
          opcode   <= {op_sr[OPW-2:0], sdi_s};
          op_valid <= 1'b1;
        end
      end else if (in_data) begin
        data_sr <= {data_sr[STAT_W-2:0], sdi_s};
      end
    end
  end

  assign id_active = op_valid && (opcode == OP_RDID);
endmodule

// File: rtl/spi_id_shifter.sv
module spi_id_shifter #(
  parameter int                    ID_BYTES = 3,
  parameter logic [ID_BYTES*8-1:0] ID_VALUE = 24'hBF258C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_fall,
  input  logic cs_rise,
  input  logic id_active,
  output logic sdo,
  output logic sdo_en
);
  localparam int ID_BITS = ID_BYTES * 8;
  localparam int PW      = $clog2(ID_BITS);
  localparam logic [PW-1:0] POS_END = PW'(ID_BITS - 1);

  logic [PW-1:0] pos;

  function automatic logic [PW-1:0] next_pos(input logic [PW-1:0] p);
    return (p == POS_END) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (cs_rise) begin
      pos    <= '0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (sck_fall && id_active) begin
      sdo    <= ID_VALUE[POS_END - pos];
      sdo_en <= 1'b1;
      pos    <= next_pos(pos);
    end
  end
endmodule

// File: rtl/spi_status_regs.sv
module spi_status_regs
  import spiflash_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise,
  input  logic              op_valid,
  input  logic [7:0]        opcode,
  input  logic [CNT_W-1:0]  bitcnt,
  input  logic [STAT_W-1:0] data_sr,
  output logic [STAT_W-1:0] status_q,
  output logic              wel_q,
  output logic              ewsl_q,
  output logic              wrsr_end,
  output logic              wrsr_commit
);
  localparam logic [CNT_W-1:0] CNT_OP = CNT_W'(OPW);

  wrsr_len_e len;
  logic      op_only, set_wel, set_ewsl, enabled;

  assign len         = classify_len(32'(bitcnt));
  assign op_only     = cs_rise && op_valid && (bitcnt == CNT_OP);
  assign set_wel     = op_only && (opcode == OP_WREN);
  assign set_ewsl    = op_only && (opcode == OP_EWSR);
  assign enabled     = wel_q || ewsl_q;
  assign wrsr_end    = cs_rise && op_valid && (opcode == OP_WRSR);
  assign wrsr_commit = wrsr_end && enabled && (len != LEN_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      wel_q    <= 1'b0;
      ewsl_q   <= 1'b0;
    end else begin
      if (wrsr_commit) status_q <= wrsr_merge(status_q, data_sr, len);
      if (wrsr_end) begin
        wel_q  <= 1'b0;
        ewsl_q <= 1'b0;
      end else begin
        if (set_wel)  wel_q  <= 1'b1;
        if (set_ewsl) ewsl_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spiflash_front.sv
module spiflash_front
  import spiflash_pkg::*;
#(
  parameter int                    SYNC_STAGES = 2,
  parameter int                    CNT_W       = 6,
  parameter int                    ID_BYTES    = 3,
  parameter logic [ID_BYTES*8-1:0] ID_VALUE    = 24'hBF258C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        sdi,
  output logic        sdo,
  output logic        sdo_en,
  output logic [15:0] status_q,
  output logic        wel_q,
  output logic        ewsl_q
);
  // named internal events, also watched by the bound checker
  logic              sdi_s, sck_rise, sck_fall, cs_rise, cs_fall;
  logic [CNT_W-1:0]  bitcnt;
  logic [7:0]        opcode;
  logic              op_valid, id_active;
  logic [STAT_W-1:0] data_sr;
  logic              wrsr_end, wrsr_commit;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdi_s(sdi_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_rise(cs_rise), .cs_fall(cs_fall)
  );

  spi_cmd_decode #(.CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .cs_rise(cs_rise),
    .cs_fall(cs_fall), .sdi_s(sdi_s), .bitcnt(bitcnt), .opcode(opcode),
    .op_valid(op_valid), .data_sr(data_sr), .id_active(id_active)
  );

  spi_id_shifter #(.ID_BYTES(ID_BYTES), .ID_VALUE(ID_VALUE)) u_id (
    .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .cs_rise(cs_rise),
    .id_active(id_active), .sdo(sdo), .sdo_en(sdo_en)
  );

  spi_status_regs #(.CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .op_valid(op_valid),
    .opcode(opcode), .bitcnt(bitcnt), .data_sr(data_sr),
    .status_q(status_q), .wel_q(wel_q), .ewsl_q(ewsl_q),
    .wrsr_end(wrsr_end), .wrsr_commit(wrsr_commit)
  );
endmodule

// File: rtl/spiflash_front_chk.sv
module spiflash_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sdo_en,
  input logic        sck_fall,
  input logic        cs_rise,
  input logic        id_active,
  input logic        op_valid,
  input logic [15:0] status_q,
  input logic        wel_q,
  input logic        ewsl_q,
  input logic        wrsr_end,
  input logic        wrsr_commit
);
  p_drive_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> $past(sck_fall));

  p_hiz_no_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !sdo_en);

  p_drive_only_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> id_active);

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sdo_en);

  p_wel_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(cs_rise));

  p_ewsl_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ewsl_q) |-> $past(cs_rise));

  p_status_commit_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_q) |-> $past(wrsr_commit));

  p_commit_needs_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_commit |-> (wel_q || ewsl_q));

  p_clear_latches_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_end |=> (!wel_q && !ewsl_q));
endmodule

bind spiflash_front spiflash_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdo_en(sdo_en), .sck_fall(sck_fall),
  .cs_rise(cs_rise), .id_active(id_active), .op_valid(op_valid),
  .status_q(status_q), .wel_q(wel_q), .ewsl_q(ewsl_q),
  .wrsr_end(wrsr_end), .wrsr_commit(wrsr_commit)
);

// File: tb/sim_spiflash_front.sv
`timescale 1ns/1ps
module sim_spiflash_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en, wel_q, ewsl_q;
  logic [15:0] status_q;

  int errors = 0, checks = 0;
  logic [15:0] m_stat = '0;
  logic m_wel = 1'b0, m_ewsl = 1'b0;
  logic [127:0] rx_d, rx_e;

  localparam int HALF = 8;

  always #2.5 clk = ~clk;

  spiflash_front u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .status_q(status_q),
    .wel_q(wel_q), .ewsl_q(ewsl_q)
  );

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // identifier bit k of the repeating stream, byte by byte
  function automatic logic id_exp(input int k);
    logic [7:0] b;
    case ((k / 8) % 3)
      0: b = 8'hBF;
      1: b = 8'h25;
      default: b = 8'h8C;
    endcase
    return b[7 - (k % 8)];
  endfunction

  // expected register effects of one finished frame
  task automatic model(input int nb, input logic [39:0] w);
    logic [7:0] op;
    op = w[39:32];
    if (nb < 8) return;
    if (op == 8'h06 && nb == 8) m_wel = 1'b1;
    if (op == 8'h50 && nb == 8) m_ewsl = 1'b1;
    if (op == 8'h01) begin
      if (m_wel || m_ewsl) begin
        if (nb == 16) m_stat[7:0] = w[31:24];
        else if (nb == 24) m_stat = {w[23:16], w[31:24]};
      end
      m_wel = 1'b0;
      m_ewsl = 1'b0;
    end
  endtask

  // one frame: nb bits taken MSB first from w, zeros beyond 40 bits
  task automatic frame(input bit m3, input int nb, input logic [39:0] w);
    rx_d = '0;
    rx_e = '0;
    sck = m3;
    waitc(10);
    cs_n = 1'b0;
    waitc(HALF);
    for (int i = 0; i < nb; i++) begin
      sck = 1'b0;
      sdi = (i < 40) ? w[39 - i] : 1'b0;
      waitc(HALF);
      rx_d[i] = sdo;
      rx_e[i] = sdo_en;
      sck = 1'b1;
      waitc(HALF);
    end
    if (!m3) begin
      sck = 1'b0;
      waitc(HALF);
    end
    cs_n = 1'b1;
    waitc(10);
    model(nb, w);
  endtask

  task automatic check_frame(input string tag_st, input string tag_l, input int nb, input logic [7:0] op);
    logic okd, oke;
    check(status_q == m_stat, tag_st, {16'h0, status_q}, {16'h0, m_stat});
    check(wel_q == m_wel && ewsl_q == m_ewsl, tag_l, {30'h0, wel_q, ewsl_q}, {30'h0, m_wel, m_ewsl});
    check(sdo_en == 1'b0, "R4 sdo_en after frame", {31'h0, sdo_en}, 32'h0);
    oke = 1'b1;
    for (int i = 0; i < nb && i < 8; i++) if (rx_e[i] !== 1'b0) oke = 1'b0;
    check(oke, "R2 hiz during opcode", rx_e[31:0], 32'h0);
    if (nb >= 8) begin
      okd = 1'b1;
      oke = 1'b1;
      for (int i = 8; i < nb && i < 128; i++) begin
        if (op == 8'h9F) begin
          if (rx_e[i] !== 1'b1 || rx_d[i] !== id_exp(i - 8)) okd = 1'b0;
        end else if (rx_e[i] !== 1'b0) oke = 1'b0;
      end
      if (op == 8'h9F) check(okd, "R3 id stream", rx_d[39:8], {id_exp(0), id_exp(1), id_exp(2), id_exp(3)});
      else check(oke, "R2 hiz non-id frame", rx_e[39:8], 32'h0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    waitc(5);
    check(status_q == 16'h0 && wel_q == 1'b0 && ewsl_q == 1'b0 && sdo_en == 1'b0,
          "R11 reset state", {13'h0, sdo_en, wel_q, ewsl_q, status_q}, 32'h0);
    rst_n = 1'b1;
    waitc(4);

    // R3 R1: id read in mode 0, long enough to wrap twice
    frame(1'b0, 8 + 60, {8'h9F, 32'h0});
    check_frame("R3 status", "R3 latches", 68, 8'h9F);
    // R1: id read in mode 3
    frame(1'b1, 8 + 24, {8'h9F, 32'h0});
    check_frame("R1 status", "R1 latches", 32, 8'h9F);
    // R4: id read cut mid-byte
    frame(1'b0, 8 + 13, {8'h9F, 32'h0});
    check_frame("R4 status", "R4 latches", 21, 8'h9F);
    // R9: status write with no enable first
    frame(1'b0, 16, {8'h01, 8'hA5, 24'h0});
    check_frame("R9 status", "R9 latches", 16, 8'h01);
    // R5: 06h then R6 byte form in mode 3
    frame(1'b1, 8, {8'h06, 32'h0});
    check_frame("R5 status", "R5 wel set", 8, 8'h06);
    frame(1'b1, 16, {8'h01, 8'h3C, 24'h0});
    check_frame("R6 byte write", "R10 latches", 16, 8'h01);
    // R5: 50h then R7 word form in mode 0
    frame(1'b0, 8, {8'h50, 32'h0});
    check_frame("R5 status", "R5 ewsl set", 8, 8'h50);
    frame(1'b0, 24, {8'h01, 8'h12, 8'hE7, 16'h0});
    check_frame("R7 word write", "R10 latches", 24, 8'h01);
    // R8: truncated by a partial byte, then over-long
    frame(1'b0, 8, {8'h06, 32'h0});
    frame(1'b0, 20, {8'h01, 8'hFF, 8'hFF, 16'h0});
    check_frame("R8 partial", "R10 latches", 20, 8'h01);
    frame(1'b1, 8, {8'h50, 32'h0});
    frame(1'b1, 25, {8'h01, 8'h00, 8'h00, 16'hFFFF});
    check_frame("R8 overlong", "R10 latches", 25, 8'h01);
    // R5: enable frame with extra bits must not set the latch
    frame(1'b0, 9, {8'h06, 32'h0});
    check_frame("R5 status", "R5 long enable", 9, 8'h06);
    // R2: unknown opcode
    frame(1'b0, 24, {8'hC3, 32'hFFFF_FFFF});
    check_frame("R2 status", "R2 latches", 24, 8'hC3);

    for (int n = 0; n < 60; n++) begin
      bit m3;
      int sel, nb;
      logic [39:0] w;
      logic [7:0] op;
      string ts, tl;
      m3 = 1'($urandom % 2);
      sel = int'($urandom % 6);
      w[31:0] = $urandom;
      w[39:32] = 8'($urandom);
      case (sel)
        0: op = 8'h06;
        1: op = 8'h50;
        2, 3: op = 8'h01;
        4: op = 8'h9F;
        default: op = (w[39:32] == 8'h06 || w[39:32] == 8'h50 || w[39:32] == 8'h01 || w[39:32] == 8'h9F) ? 8'h77 : w[39:32];
      endcase
      w[39:32] = op;
      if (op == 8'h01) begin
        case ($urandom % 4)
          0: nb = 16;
          1: nb = 24;
          default: nb = 9 + int'($urandom % 32);
        endcase
      end else if (op == 8'h9F) nb = 8 + int'($urandom % 40);
      else nb = ($urandom % 3 == 0) ? 4 + int'($urandom % 20) : 8;
      if (op == 8'h01) begin
        if (!(m_wel || m_ewsl)) ts = "R9 random status";
        else if (nb == 16) ts = "R6 random status";
        else if (nb == 24) ts = "R7 random status";
        else ts = "R8 random status";
        tl = "R10 random latches";
      end else begin
        ts = "R1 random status";
        tl = "R5 random latches";
      end
      frame(m3, nb, w);
      check_frame(ts, tl, nb, op);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule